// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block turns the input lines of three 8-bit GPIO ports into interrupt requests. Each line is synchronised to the core clock and can be set up to raise a request either while it sits at a chosen level or when it makes a chosen transition. Two ports (index 0 and 1) are merged onto one shared request output. The third port (index 2) has one request output per line, so software can route each of its lines on its own.

Software drives the block through a small register interface, one set per port. A mode plane picks level or edge per line. A polarity plane picks low/falling or high/rising. An enable plane gates what is reported. A write-one acknowledge clears latched edges, and a status view shows what is pending. To trigger on both edges, software inverts the polarity bit on every acknowledge. Each line's edge latch is a two-state machine: `LATCH_IDLE` goes to `LATCH_HELD` on a qualifying edge (`arm`). `LATCH_HELD` returns to `LATCH_IDLE` on an acknowledge with no new edge in that cycle (`release`), or when the line is switched to level mode (`discard`). An edge and an acknowledge in the same cycle leave it in `LATCH_HELD` (`rearm`).

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every mode, polarity and enable register reads 0, every status reads 0, and `irq_ab` and `irq_f` are low.
- R2: `reg_addr[4:3]` selects the port (0, 1, 2) and `reg_addr[2:0]` the field: 0 mode, 1 polarity, 2 enable, 3 acknowledge, 4 status. A write with `reg_wr` high updates mode, polarity and enable at the clock edge, and they read back on `reg_rdata` combinationally.
- R3: A line with mode bit 0 is pending while its synchronised input equals its polarity bit (1 = high, 0 = low) and it is enabled. A pin change shows on the outputs two clock edges after it is sampled.
- R4: A line with mode bit 1 latches a rising edge (polarity 1) or a falling edge (polarity 0). It becomes pending three clock edges after the pin change is sampled and stays pending after the pin returns.
- R5: Writing the acknowledge field clears the latch of every line whose data bit is 1. Lines whose bit is 0 are left unchanged.
- R6: An edge detected in the same cycle as an acknowledge of that line leaves the line pending.
- R7: A line whose enable bit is 0 is never pending, and an edge that occurs while it is disabled is not latched.
- R8: `irq_ab` is high exactly when some line of port 0 or port 1 is pending.
- R9: `irq_f[i]` is high exactly when line i of port 2 is pending, independently of the other lines.
- R10: The status field reads the pending bits of the selected port. The acknowledge field reads 0. Port index 3 reads 0 and writes to it are ignored.
- R11: Setting a line's mode bit to 0 discards its latched edge, so switching it back to edge mode shows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 8 | Asynchronous lines of port 0 |
| pin_b | input | 8 | Asynchronous lines of port 1 |
| pin_f | input | 8 | Asynchronous lines of port 2 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Port select (bits 4:3) and field select (bits 2:0) |
| reg_wdata | input | 8 | Write data, one bit per line |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_ab | output | 1 | Shared request of ports 0 and 1 |
| irq_f | output | 8 | Per-line requests of port 2 |

## Verification
On every cycle the assertions check four things. The outputs are quiet on leaving reset. Clearing port 2's enable silences `irq_f` one edge later. The status reads agree with the request outputs. No request rises unless a register write or a pin change came just before it, at the synchroniser distance. The precise latencies of level and edge detection, the effect of write-zero acknowledges, the edge-during-acknowledge race, disabled edges being dropped and latches being discarded on a mode change can only be shown by the bench's scripted pin and register sequences.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    localparam int NUM_PORTS  = 3;
    localparam int PORT_SEL_W = 2;
    localparam int FIELD_W    = 3;
    localparam int ADDR_W     = PORT_SEL_W + FIELD_W;
    localparam int PORT_SHARED0 = 0;
    localparam int PORT_SHARED1 = 1;
    localparam int PORT_SPLIT   = 2;

    typedef enum logic [FIELD_W-1:0] {
        FLD_MODE = 3'd0,
        FLD_POL  = 3'd1,
        FLD_ENA  = 3'd2,
        FLD_ACK  = 3'd3,
        FLD_STAT = 3'd4
    } field_e;

    typedef enum logic {
        LATCH_IDLE = 1'b0,
        LATCH_HELD = 1'b1
    } latch_st_e;

    function automatic logic [ADDR_W-1:0] addr_of(input int port, input field_e fld);
        return {PORT_SEL_W'(port), fld};
    endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= raw;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/gpio_irq_line.sv
`timescale 1ns/1ps
module gpio_irq_line
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic prev,
    input  logic mode_edge,
    input  logic pol_high,
    input  logic ena,
    input  logic ack,
    output logic pend
);
    latch_st_e state, state_nx;
    logic      edge_hit;

    assign edge_hit = mode_edge && ena &&
                      (pol_high ? (cur && !prev) : (!cur && prev));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LATCH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LATCH_IDLE: if (edge_hit) state_nx = LATCH_HELD;
            LATCH_HELD: begin
                if (!mode_edge)          state_nx = LATCH_IDLE;
                else if (ack && !edge_hit) state_nx = LATCH_IDLE;
            end
            default: state_nx = LATCH_IDLE;
        endcase
    end

    always_comb begin
        if (!ena)           pend = 1'b0;
        else if (mode_edge) pend = (state == LATCH_HELD);
        else                pend = (cur == pol_high);
    end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pins,
    input  logic             wr,
    input  logic             sel,
    input  field_e           fld,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] mode_q,
    output logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] ena_q,
    output logic [LINES-1:0] pend
);
    logic [LINES-1:0] cur, prev, ack_vec;
    logic             hit;

    assign hit     = wr && sel;
    assign ack_vec = (hit && fld == FLD_ACK) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '0;
            ena_q  <= '0;
        end else if (hit) begin
            if (fld == FLD_MODE) mode_q <= wdata;
            if (fld == FLD_POL)  pol_q  <= wdata;
            if (fld == FLD_ENA)  ena_q  <= wdata;
        end
    end

    gpio_irq_sync #(.W(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pins),
        .cur  (cur),
        .prev (prev)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_irq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .cur      (cur[i]),
            .prev     (prev[i]),
            .mode_edge(mode_q[i]),
            .pol_high (pol_q[i]),
            .ena      (ena_q[i]),
            .ack      (ack_vec[i]),
            .pend     (pend[i])
        );
    end
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINES-1:0]     pin_a,
    input  logic [LINES-1:0]     pin_b,
    input  logic [LINES-1:0]     pin_f,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [LINES-1:0]     reg_wdata,
    output logic [LINES-1:0]     reg_rdata,
    output logic                 irq_ab,
    output logic [LINES-1:0]     irq_f
);
    logic [LINES-1:0]      pins   [NUM_PORTS];
    logic [LINES-1:0]      mode_q [NUM_PORTS];
    logic [LINES-1:0]      pol_q  [NUM_PORTS];
    logic [LINES-1:0]      ena_q  [NUM_PORTS];
    logic [LINES-1:0]      pend   [NUM_PORTS];
    logic [PORT_SEL_W-1:0] port_idx;
    field_e                fld;

    assign port_idx = reg_addr[ADDR_W-1:FIELD_W];
    assign fld      = field_e'(reg_addr[FIELD_W-1:0]);

    assign pins[PORT_SHARED0] = pin_a;
    assign pins[PORT_SHARED1] = pin_b;
    assign pins[PORT_SPLIT]   = pin_f;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_irq_port #(.LINES(LINES)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .pins  (pins[p]),
            .wr    (reg_wr),
            .sel   (port_idx == PORT_SEL_W'(p)),
            .fld   (fld),
            .wdata (reg_wdata),
            .mode_q(mode_q[p]),
            .pol_q (pol_q[p]),
            .ena_q (ena_q[p]),
            .pend  (pend[p])
        );
    end

    assign irq_ab = |(pend[PORT_SHARED0] | pend[PORT_SHARED1]);
    assign irq_f  = pend[PORT_SPLIT];

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_idx == PORT_SEL_W'(p)) begin
                case (fld)
                    FLD_MODE: reg_rdata = mode_q[p];
                    FLD_POL:  reg_rdata = pol_q[p];
                    FLD_ENA:  reg_rdata = ena_q[p];
                    FLD_STAT: reg_rdata = pend[p];
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
`timescale 1ns/1ps
module gpio_irq_detect_chk
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LINES-1:0]  pin_a,
    input logic [LINES-1:0]  pin_b,
    input logic [LINES-1:0]  pin_f,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [LINES-1:0]  reg_wdata,
    input logic [LINES-1:0]  reg_rdata,
    input logic              irq_ab,
    input logic [LINES-1:0]  irq_f
);
    localparam logic [ADDR_W-1:0] A_SPLIT_ENA  = addr_of(PORT_SPLIT, FLD_ENA);
    localparam logic [ADDR_W-1:0] A_SPLIT_STAT = addr_of(PORT_SPLIT, FLD_STAT);
    localparam logic [ADDR_W-1:0] A_S0_STAT    = addr_of(PORT_SHARED0, FLD_STAT);
    localparam logic [ADDR_W-1:0] A_S1_STAT    = addr_of(PORT_SHARED1, FLD_STAT);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_ab && irq_f == '0));

    assert_disable_silences_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SPLIT_ENA && reg_wdata == '0) |=> (irq_f == '0));

    assert_split_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SPLIT_STAT) |-> (reg_rdata == irq_f));

    assert_shared_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr == A_S0_STAT || reg_addr == A_S1_STAT) && reg_rdata != '0) |-> irq_ab);

    assert_split_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_f & ~$past(irq_f))) |->
            ($past(reg_wr) || ($past(pin_f, 2) != $past(pin_f, 3)) ||
             ($past(pin_f, 3) != $past(pin_f, 4))));

    assert_shared_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ab) |->
            ($past(reg_wr) ||
             ($past(pin_a, 2) != $past(pin_a, 3)) || ($past(pin_a, 3) != $past(pin_a, 4)) ||
             ($past(pin_b, 2) != $past(pin_b, 3)) || ($past(pin_b, 3) != $past(pin_b, 4))));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_a    (pin_a),
    .pin_b    (pin_b),
    .pin_f    (pin_f),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_ab   (irq_ab),
    .irq_f    (irq_f)
);

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/1ps
module gpio_irq_detect_test;
    import gpio_irq_pkg::*;

    localparam int K_RDATA = 0;
    localparam int K_IRQF  = 1;
    localparam int K_IRQAB = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_a = '0, pin_b = '0, pin_f = '0;
    logic       reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ab;
    logic [7:0] irq_f;

    int applied = 0;
    int failed  = 0;
    bit done    = 1'b0;

    int         kind_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    gpio_irq_detect uut (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_f(pin_f),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (kind_q.size() > 0) begin
                int         k;
                logic [7:0] e, a;
                string      t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (k == K_RDATA)     a = reg_rdata;
                else if (k == K_IRQF) a = irq_f;
                else                  a = {7'd0, irq_ab};
                applied++;
                if (a !== e) begin
                    failed++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic expect_item(input int k, input logic [7:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
        wait (kind_q.size() == 0);
    endtask

    task automatic wr(input int port, input field_e f, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = addr_of(port, f);
        reg_wdata = d;
        tick(1);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input int port, input field_e f, input logic [7:0] e, input string t);
        reg_addr = addr_of(port, f);
        expect_item(K_RDATA, e, t);
    endtask

    task automatic setup(input int port, input logic [7:0] m, input logic [7:0] p, input logic [7:0] en);
        wr(port, FLD_ENA, 8'h00);
        wr(port, FLD_MODE, m);
        wr(port, FLD_POL, p);
        wr(port, FLD_ENA, en);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failed++;
            $display("FAIL watchdog R1..R11 run actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        expect_item(K_IRQF, 8'h00, "R1 irq_f after reset");
        expect_item(K_IRQAB, 8'h00, "R1 irq_ab after reset");
        rd(PORT_SPLIT, FLD_MODE, 8'h00, "R1 mode reset");
        rd(PORT_SHARED0, FLD_ENA, 8'h00, "R1 enable reset");
        rd(PORT_SHARED1, FLD_STAT, 8'h00, "R1 status reset");

        // R2 write/readback
        wr(PORT_SHARED0, FLD_MODE, 8'h5A);
        wr(PORT_SHARED1, FLD_POL, 8'hC3);
        rd(PORT_SHARED0, FLD_MODE, 8'h5A, "R2 mode readback");
        rd(PORT_SHARED1, FLD_POL, 8'hC3, "R2 polarity readback");
        wr(PORT_SHARED0, FLD_MODE, 8'h00);
        wr(PORT_SHARED1, FLD_POL, 8'h00);

        // R10 port 3 and ack field
        wr(3, FLD_MODE, 8'hFF);
        rd(3, FLD_MODE, 8'h00, "R10 port 3 reads zero");
        rd(PORT_SPLIT, FLD_MODE, 8'h00, "R10 port 3 write ignored");
        rd(PORT_SPLIT, FLD_ACK, 8'h00, "R10 ack field reads zero");

        // R3 level high on line 1, level low on line 2
        setup(PORT_SPLIT, 8'h00, 8'h02, 8'h06);
        expect_item(K_IRQF, 8'h04, "R3 level-low line pending");
        pin_f[1] = 1'b1;
        tick(1);
        expect_item(K_IRQF, 8'h04, "R3 level latency one edge");
        tick(1);
        expect_item(K_IRQF, 8'h06, "R3 level-high after two edges");
        wr(PORT_SPLIT, FLD_ENA, 8'h00);
        expect_item(K_IRQF, 8'h00, "R7 disabled level hidden");
        pin_f[1] = 1'b0;
        tick(4);

        // R4 rising edge on line 0
        setup(PORT_SPLIT, 8'h01, 8'h01, 8'h01);
        pin_f[0] = 1'b1;
        tick(2);
        expect_item(K_IRQF, 8'h00, "R4 not yet latched");
        tick(1);
        expect_item(K_IRQF, 8'h01, "R4 rising latched after three edges");
        pin_f[0] = 1'b0;
        tick(4);
        expect_item(K_IRQF, 8'h01, "R4 latch holds after pin returns");
        rd(PORT_SPLIT, FLD_STAT, 8'h01, "R10 status shows pending");

        // R5 acknowledge
        wr(PORT_SPLIT, FLD_ACK, 8'hFE);
        expect_item(K_IRQF, 8'h01, "R5 zero bit leaves latch");
        wr(PORT_SPLIT, FLD_ACK, 8'h01);
        expect_item(K_IRQF, 8'h00, "R5 one bit clears latch");

        // R6 edge coincides with acknowledge
        pin_f[0] = 1'b1;
        tick(4);
        pin_f[0] = 1'b0;
        tick(4);
        expect_item(K_IRQF, 8'h01, "R6 precondition latched");
        pin_f[0] = 1'b1;
        tick(2);
        wr(PORT_SPLIT, FLD_ACK, 8'h01);
        expect_item(K_IRQF, 8'h01, "R6 edge during ack kept");
        wr(PORT_SPLIT, FLD_ACK, 8'h01);
        expect_item(K_IRQF, 8'h00, "R5 ack without edge clears");

        // R4 falling edge, R7 edge while disabled
        setup(PORT_SPLIT, 8'h01, 8'h00, 8'h01);
        tick(2);
        expect_item(K_IRQF, 8'h00, "R4 high pin not pending in falling mode");
        pin_f[0] = 1'b0;
        tick(3);
        expect_item(K_IRQF, 8'h01, "R4 falling latched");
        wr(PORT_SPLIT, FLD_ACK, 8'h01);
        wr(PORT_SPLIT, FLD_ENA, 8'h00);
        pin_f[0] = 1'b1;
        tick(4);
        pin_f[0] = 1'b0;
        tick(4);
        wr(PORT_SPLIT, FLD_ENA, 8'h01);
        expect_item(K_IRQF, 8'h00, "R7 disabled edge not latched");

        // R11 mode change discards latch
        setup(PORT_SPLIT, 8'h01, 8'h01, 8'h01);
        pin_f[0] = 1'b1;
        tick(4);
        pin_f[0] = 1'b0;
        tick(4);
        expect_item(K_IRQF, 8'h01, "R11 precondition latched");
        wr(PORT_SPLIT, FLD_MODE, 8'h00);
        expect_item(K_IRQF, 8'h00, "R11 level mode pin low");
        wr(PORT_SPLIT, FLD_MODE, 8'h01);
        expect_item(K_IRQF, 8'h00, "R11 latch discarded");

        // R9 independent lines 4 and 5
        setup(PORT_SPLIT, 8'h30, 8'h30, 8'h30);
        pin_f[5:4] = 2'b11;
        tick(4);
        expect_item(K_IRQF, 8'h30, "R9 two lines latched");
        wr(PORT_SPLIT, FLD_ACK, 8'h10);
        expect_item(K_IRQF, 8'h20, "R9 ack one line only");
        wr(PORT_SPLIT, FLD_ENA, 8'h00);
        pin_f = '0;
        tick(4);

        // R8 shared output
        expect_item(K_IRQAB, 8'h00, "R8 idle shared low");
        setup(PORT_SHARED0, 8'h00, 8'h08, 8'h08);
        pin_a[3] = 1'b1;
        tick(2);
        expect_item(K_IRQAB, 8'h01, "R8 port 0 level drives shared");
        rd(PORT_SHARED0, FLD_STAT, 8'h08, "R10 port 0 status");
        wr(PORT_SHARED0, FLD_ENA, 8'h00);
        expect_item(K_IRQAB, 8'h00, "R8 port 0 disabled");
        setup(PORT_SHARED1, 8'h80, 8'h80, 8'h80);
        pin_b[7] = 1'b1;
        tick(3);
        expect_item(K_IRQAB, 8'h01, "R8 port 1 edge drives shared");
        expect_item(K_IRQF, 8'h00, "R9 split port unaffected");
        wr(PORT_SHARED1, FLD_ACK, 8'h80);
        expect_item(K_IRQAB, 8'h00, "R8 shared clears on ack");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end
endmodule